// File: doc/BRIEF.md
# Asynchronous SRAM Access Front End

This block sits between the asynchronous control pins of a byte-wide static memory and its internal array. It registers the active-low chip enable, write enable and output enable, the open-drain busy line and a supply-low flag once on a fast internal clock. From that registered copy it decodes one of four access modes, reads or writes a register-file array of 2048 bytes, drives a separate output-enable for the data bus, and emits a one-cycle write-occurred strobe. A store sequencer uses that strobe to decide whether a nonvolatile store is needed.

When the busy line falls, the front end opens a grace window of `GRACE_CYC` cycles. Reads keep working during the window, and a write already under way may still finish. A write that begins inside the window is refused. When the window expires the block enters nonvolatile mode: the data bus is released and an unfinished write is dropped. While the supply-low flag is high, no write is ever committed.

Top module: `sram_front`

## Requirements
- R1: After reset, `dataOe` is 0, `mode` is 0 (standby) and `writeDone` is 0.
- R2: `mode` encodes 0 standby, 1 read, 2 write, 3 nonvolatile. It is decided by priority: busy low with the grace window expired gives 3; otherwise chip enable high gives 0; otherwise write enable high gives 1; otherwise 2. The result appears two clock edges after the inputs change.
- R3: In read mode with output enable low, `dataOut` shows the byte stored at `addr` two edges later. An address change alone updates it, with no control transition.
- R4: `dataOe` is high only when the decoded mode is read and output enable is low. This holds for writes too: a write with output enable low keeps the bus released.
- R5: A write is accepted when chip enable and write enable are both low, busy is high and supply-low is clear. It completes at the first rise of either enable. The stored byte and address are the values sampled in the last cycle in which both enables were low.
- R6: `writeDone` pulses high for exactly one cycle per accepted write, two edges after the completing input rise, and never for a refused write.
- R7: During the grace window that follows busy falling, reads continue and a write already under way completes. A write that begins in the window is refused and leaves the array unchanged.
- R8: When the grace window expires, mode becomes 3, `dataOe` is 0, and a write still under way is dropped without a strobe.
- R9: A write that starts, or is under way, while `lowSupply` is high is dropped, with no array update and no strobe.
- R10: A refused write stays refused while both enables remain low, even after the blocking condition clears. Only a fresh low phase of the enables is treated as a new write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast internal sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| busyN | input | 1 | Busy line; low requests nonvolatile mode |
| lowSupply | input | 1 | Supply below switch level, from the voltage monitor |
| addr | input | 11 | Byte address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data |
| dataOe | output | 1 | Drive enable for the data bus |
| mode | output | 2 | Decoded access mode |
| writeDone | output | 1 | One-cycle strobe per accepted write |

## Verification
A corrupted write-tracking state has two visible effects. A write can be lost, which is caught when a later read returns the old byte. A strobe can be missing or doubled, which shows in the `writeDone` count three cycles after the enable rises. A wrong grace counter either releases the bus too early during a read or lets a refused write land. Both show within a dozen cycles of busy falling, as a wrong `mode`, a wrong `dataOe`, or a wrong byte on the next read. A mode decode error shows on `mode` and `dataOe` two edges after the inputs change.

// File: rtl/sram_front_pkg.sv
package sram_front_pkg;

  typedef enum logic [1:0] {
    MODE_STBY  = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_NV    = 2'd3
  } accMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch address/data of the write in flight
    logic commit;   // write latched byte into the array
    logic outEn;    // next-cycle bus drive enable
  } ctrlStrobe_t;

endpackage

// File: rtl/sram_front_dp.sv
module sram_front_dp
  import sram_front_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              busyN,
  input  logic              lowSupply,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrlStrobe_t       strobe,
  output logic              sCeN,
  output logic              sWeN,
  output logic              sOeN,
  output logic              sBusyN,
  output logic              sLow,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] sAddr;
  logic [DATA_W-1:0] sData;
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData;
  logic [DATA_W-1:0] memArr [DEPTH];

  // single sampling stage for the asynchronous pins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sCeN   <= 1'b1;
      sWeN   <= 1'b1;
      sOeN   <= 1'b1;
      sBusyN <= 1'b1;
      sLow   <= 1'b0;
      sAddr  <= '0;
      sData  <= '0;
    end else begin
      sCeN   <= ceN;
      sWeN   <= weN;
      sOeN   <= oeN;
      sBusyN <= busyN;
      sLow   <= lowSupply;
      sAddr  <= addr;
      sData  <= dataIn;
    end
  end

  // write holding register: last address/data seen with both enables low
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrAddr <= '0;
      wrData <= '0;
    end else if (strobe.capture) begin
      wrAddr <= sAddr;
      wrData <= sData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.commit) memArr[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOe  <= 1'b0;
      dataOut <= '0;
    end else begin
      dataOe <= strobe.outEn;
      if (strobe.outEn) dataOut <= memArr[sAddr];
    end
  end

  // R5: commit and capture of a new write never fall in the same cycle
  a_r5_commit_after_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> !strobe.capture);

endmodule

// File: rtl/sram_front_ctrl.sv
module sram_front_ctrl
  import sram_front_pkg::*;
#(
  parameter int GRACE_CYC = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sCeN,
  input  logic        sWeN,
  input  logic        sOeN,
  input  logic        sBusyN,
  input  logic        sLow,
  output ctrlStrobe_t strobe,
  output accMode_e    modeQ,
  output logic        writeDone
);

  localparam int CNT_W = $clog2(GRACE_CYC + 1);
  localparam logic [CNT_W-1:0] GRACE_MAX = CNT_W'(GRACE_CYC);

  logic             wrActive;
  logic             wrBlocked;
  logic [CNT_W-1:0] graceCnt;
  logic             bothLow, nvNow, startOk, holdOk, finishOk;
  accMode_e         modeNext;

  always_comb begin
    bothLow  = !sCeN && !sWeN;
    nvNow    = !sBusyN && (graceCnt == GRACE_MAX);
    startOk  = bothLow && !wrActive && !wrBlocked && sBusyN && !sLow;
    holdOk   = wrActive && bothLow && !sLow && !nvNow;
    finishOk = wrActive && !bothLow && !sLow && !nvNow;

    if (nvNow)      modeNext = MODE_NV;
    else if (sCeN)  modeNext = MODE_STBY;
    else if (sWeN)  modeNext = MODE_READ;
    else            modeNext = MODE_WRITE;

    strobe.capture = startOk || holdOk;
    strobe.commit  = finishOk;
    strobe.outEn   = (modeNext == MODE_READ) && !sOeN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrActive  <= 1'b0;
      wrBlocked <= 1'b0;
      graceCnt  <= '0;
      modeQ     <= MODE_STBY;
      writeDone <= 1'b0;
    end else begin
      wrActive  <= startOk || holdOk;
      // a low phase that is not an accepted write stays refused until it ends
      wrBlocked <= bothLow && !(startOk || holdOk);
      if (sBusyN)                   graceCnt <= '0;
      else if (graceCnt != GRACE_MAX) graceCnt <= graceCnt + 1'b1;
      modeQ     <= modeNext;
      writeDone <= finishOk;
    end
  end

  // R6: strobe is a single-cycle pulse
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    writeDone |=> !writeDone);

  // R8: no strobe while reporting nonvolatile mode
  a_r8_nv_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_NV) |-> !writeDone);

  // R9: supply-low in a cycle forbids a strobe in the next
  a_r9_low_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    sLow |=> !writeDone);

  // R7: grace counter never runs past its limit
  a_r7_grace_bound: assert property (@(posedge clk) disable iff (!rstN)
    graceCnt <= GRACE_MAX);

endmodule

// File: rtl/sram_front.sv
module sram_front
  import sram_front_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int GRACE_CYC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              busyN,
  input  logic              lowSupply,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic [1:0]        mode,
  output logic              writeDone
);

  ctrlStrobe_t strobe;
  accMode_e    modeQ;
  logic        sCeN, sWeN, sOeN, sBusyN, sLow;

  sram_front_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN),
    .ceN(ceN), .weN(weN), .oeN(oeN), .busyN(busyN), .lowSupply(lowSupply),
    .addr(addr), .dataIn(dataIn), .strobe(strobe),
    .sCeN(sCeN), .sWeN(sWeN), .sOeN(sOeN), .sBusyN(sBusyN), .sLow(sLow),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  sram_front_ctrl #(.GRACE_CYC(GRACE_CYC)) uCtrl (
    .clk(clk), .rstN(rstN),
    .sCeN(sCeN), .sWeN(sWeN), .sOeN(sOeN), .sBusyN(sBusyN), .sLow(sLow),
    .strobe(strobe), .modeQ(modeQ), .writeDone(writeDone)
  );

  assign mode = modeQ;

  // R4: bus driven only in read mode
  a_r4_oe_read_only: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (modeQ == MODE_READ));

endmodule

// File: tb/sim_sram_front.sv
module sim_sram_front;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ceN = 1'b1, weN = 1'b1, oeN = 1'b1, busyN = 1'b1, lowSupply = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  dataOut;
  logic        dataOe;
  logic [1:0]  mode;
  logic        writeDone;

  always #2 clk = ~clk;  // 250 MHz

  sram_front u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .busyN(busyN),
    .lowSupply(lowSupply), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe), .mode(mode), .writeDone(writeDone)
  );

  typedef struct {
    int    due;
    int    field;   // 0 read data, 1 dataOe, 2 mode, 3 strobe count
    int    val;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int cyc = 0;
  int tests = 0;
  int fails = 0;
  int wdCount = 0;
  int expWd = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: count strobes, then compare every item due now
  always @(negedge clk) begin
    if (rstN && writeDone) wdCount = wdCount + 1;
    while (expQ.size() > 0 && expQ[0].due <= cyc) begin
      expItem_t it;
      int act;
      bit ok;
      it = expQ.pop_front();
      case (it.field)
        0: begin act = dataOe ? int'(dataOut) : -1; ok = (dataOe === 1'b1) && (dataOut === it.val[7:0]); end
        1: begin act = int'(dataOe); ok = (dataOe === it.val[0]); end
        2: begin act = int'(mode); ok = (mode === it.val[1:0]); end
        default: begin act = wdCount; ok = (wdCount == it.val); end
      endcase
      if (it.due != cyc) ok = 0;
      tests++;
      if (!ok) begin
        fails++;
        $display("FAIL %s field %0d: actual %0d expected %0d (cycle %0d)", it.tag, it.field, act, it.val, cyc);
      end
    end
  end

  task automatic push(input int field, input int val, input string tag, input int dly);
    expItem_t it;
    it.due = cyc + dly; it.field = field; it.val = val; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic idle();
    ceN = 1; weN = 1; oeN = 1;
  endtask

  // write: both enables low for 2 cycles, then end by we (ceFirst=0) or ce
  task automatic doWrite(input logic [10:0] a, input logic [7:0] d, input bit ceFirst,
                         input bit accepted, input string tag);
    addr = a; dataIn = d; ceN = 0; weN = 0; oeN = 1;
    step(2);
    if (ceFirst) ceN = 1; else weN = 1;
    if (accepted) expWd++;
    push(3, expWd, tag, 3);
    step(1);
    idle();
    step(2);
  endtask

  task automatic doRead(input logic [10:0] a, input logic [7:0] d, input string tag);
    addr = a; ceN = 0; weN = 1; oeN = 0;
    push(0, d, tag, 2);
    push(2, 1, "R2", 2);
    step(3);
  endtask

  initial begin
    step(3);
    rstN = 1;
    push(1, 0, "R1", 1); push(2, 0, "R1", 1); push(3, 0, "R1", 1);
    step(2);

    // R5/R6: write ended by we, then by ce
    doWrite(11'h003, 8'hA5, 0, 1, "R6");
    doWrite(11'h7FF, 8'h3C, 1, 1, "R5");
    doRead(11'h003, 8'hA5, "R5");
    // R3: address change alone updates read data
    addr = 11'h7FF;
    push(0, 8'h3C, "R3", 2);
    step(3);
    idle();

    // R2/R4: standby, read with oe high, write with oe low
    push(2, 0, "R2", 2); push(1, 0, "R4", 2);
    step(3);
    ceN = 0; weN = 1; oeN = 1;
    push(2, 1, "R2", 2); push(1, 0, "R4", 2);
    step(3);
    addr = 11'h005; dataIn = 8'h11; ceN = 0; weN = 0; oeN = 0;
    push(2, 2, "R2", 2); push(1, 0, "R4", 2);
    step(3);
    weN = 1; oeN = 1; expWd++;
    push(3, expWd, "R6", 3);
    step(1); idle(); step(2);
    doRead(11'h005, 8'h11, "R5");
    idle();

    // R9: write under low supply dropped
    lowSupply = 1;
    doWrite(11'h003, 8'hFF, 0, 0, "R9");
    lowSupply = 0;
    doRead(11'h003, 8'hA5, "R9");
    idle();

    // R10: refused write held low stays refused after lowSupply clears
    lowSupply = 1;
    addr = 11'h003; dataIn = 8'h77; ceN = 0; weN = 0;
    step(2);
    lowSupply = 0;
    step(3);
    weN = 1; ceN = 1;
    push(3, expWd, "R10", 3);
    step(3);
    doRead(11'h003, 8'hA5, "R10");

    // R7: read continues in grace, new write refused
    addr = 11'h7FF; ceN = 0; weN = 1; oeN = 0; busyN = 0;
    push(0, 8'h3C, "R7", 2); push(2, 1, "R7", 2);
    step(3);
    addr = 11'h005; dataIn = 8'h99; ceN = 0; weN = 0; oeN = 1;
    step(2);
    idle();
    push(3, expWd, "R7", 3);
    step(3);
    // R8: grace expired -> nonvolatile, bus released
    addr = 11'h7FF; ceN = 0; weN = 1; oeN = 0;
    push(2, 3, "R8", 4); push(1, 0, "R8", 4);
    step(5);
    idle(); busyN = 1;
    step(2);
    doRead(11'h005, 8'h11, "R7");
    idle();

    // R7: write in flight when busy falls completes within grace
    addr = 11'h006; dataIn = 8'h42; ceN = 0; weN = 0; oeN = 1;
    step(2);
    busyN = 0;
    step(2);
    ceN = 1; weN = 1; expWd++;
    push(3, expWd, "R7", 3);
    step(3);
    busyN = 1;
    step(2);
    doRead(11'h006, 8'h42, "R7");
    idle();

    // R8: write in flight dropped when grace expires
    addr = 11'h005; dataIn = 8'h66; ceN = 0; weN = 0; oeN = 1;
    step(2);
    busyN = 0;
    step(14);
    ceN = 1; weN = 1;
    push(3, expWd, "R8", 3);
    step(3);
    busyN = 1;
    step(2);
    doRead(11'h005, 8'h11, "R8");
    idle();

    // R3/R5: block of writes then reads
    for (int i = 0; i < 8; i++)
      doWrite(11'(16 + i), 8'(i * 7 + 1), i[0], 1, "R6");
    for (int i = 0; i < 8; i++)
      doRead(11'(16 + i), 8'(i * 7 + 1), "R3");
    idle();
    step(4);
    done = 1;
  end

  initial begin
    wait (done == 1 || cyc > 20000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
    end
    if (expQ.size() != 0) begin
      tests++; fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", expQ.size());
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule